// File: doc/BRIEF.md
# Serial Lane Enable Gate After Clock Detection

This block decides when the serial output lanes of a display link transmitter may be switched on after the input pixel clock starts. It runs on the pixel clock. While an upstream detector reports that the clock is present, it counts the clock cycles. An internal two-bit policy field chooses the rule that turns the lanes on. The rule can be a short wait, a long wait, a short wait that also needs an alignment flag from the clock generator, or a bypass that follows the clock-present flag alone.

The enable output gates every serial lane. The policy field lives inside the block and is written through a one-cycle write strobe. The active-low power-down input acts as the block's reset. It turns the lanes off at once, clears the cycle count and restores the default policy. The clock generator and its phase comparator are outside the block and reach it only as the two flag inputs.

Top module: `cde_out_gate`

## Requirements
- R1: With policy code 2'b00 (the value after power-down), `lanes_en` goes high after the clock edge that samples the 1024th consecutive cycle with `clk_ok` high. It stays low after every earlier edge.
- R2: With policy code 2'b01, `lanes_en` goes high after the edge that samples the 2048th consecutive `clk_ok` cycle. It stays low after every earlier edge.
- R3: With policy code 2'b10, `lanes_en` is high after an edge only if at least 1024 consecutive `clk_ok` cycles have been counted and `align_ok` is high at that edge. An edge with `align_ok` low drives `lanes_en` low but does not clear the count, so `lanes_en` returns high at the first later edge where `align_ok` is high again.
- R4: With policy code 2'b11, `lanes_en` after each edge equals `clk_ok` sampled at that edge, whatever the count and `align_ok`.
- R5: While `pd_n` is low, `lanes_en` is low without waiting for a clock edge, the count is zero and the policy returns to 2'b00.
- R6: An edge that samples `clk_ok` low clears the count and drives `lanes_en` low. Counting then restarts from zero.
- R7: The count saturates at 2048 and never wraps, so `lanes_en` stays high under continuous clock presence for any length of time.
- R8: A write (`pol_we` high) loads `pol_wdata` at that edge. The new policy governs decisions from the next edge onward, and the write does not clear the count. Without a write, the policy holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input pixel clock |
| pd_n | input | 1 | Active-low power-down, asynchronous clear of the whole block |
| clk_ok | input | 1 | Clock-present flag from the clock detector |
| align_ok | input | 1 | Strobe alignment flag from the clock generator |
| pol_we | input | 1 | Policy write strobe |
| pol_wdata | input | 2 | Policy value to load |
| lanes_en | output | 1 | Enable for all serial lanes |

## Verification
Two events can fall in the same clock edge: the count reaching its threshold and the clock-present flag dropping. A second such pair is a policy write and a threshold crossing. The bench drives `clk_ok` low exactly on the edge that would have been the 1024th counted cycle and expects `lanes_en` to stay low and counting to restart. It also writes a new policy on the edge after a count under the old threshold and expects the old rule to decide that edge and the new rule the next one. Random runs with rare clock drops, power-down pulses, policy writes and alignment toggles are judged every cycle against a reference model in the bench.

// File: rtl/cde_pkg.sv
package cde_pkg;

    typedef enum logic [1:0] {
        POL_SHORT  = 2'b00,
        POL_LONG   = 2'b01,
        POL_LOCKED = 2'b10,
        POL_BYPASS = 2'b11
    } pol_e;

    typedef struct packed {
        pol_e pol;
        logic en;
    } gate_state_t;

endpackage

// File: rtl/cde_cycle_counter.sv
module cde_cycle_counter #(
    parameter  int unsigned LIMIT = 2048,
    localparam int unsigned CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          pd_n,
    input  logic          run,
    output logic [CW-1:0] cnt_d_o,
    output logic [CW-1:0] cnt_q_o
);

    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT_C) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_d_o = st_d.cnt;
    assign cnt_q_o = st_q.cnt;

endmodule

// File: rtl/cde_policy_decide.sv
module cde_policy_decide
    import cde_pkg::*;
#(
    parameter  int unsigned SHORT_WAIT = 1024,
    parameter  int unsigned LONG_WAIT  = 2048,
    localparam int unsigned CW         = $clog2(LONG_WAIT + 1)
) (
    input  pol_e          pol,
    input  logic [CW-1:0] cnt,
    input  logic          present,
    input  logic          aligned,
    output logic          allow
);

    localparam logic [CW-1:0] SHORT_C = CW'(SHORT_WAIT);
    localparam logic [CW-1:0] LONG_C  = CW'(LONG_WAIT);

    logic reach_short;
    logic reach_long;

    always_comb begin
        reach_short = (cnt >= SHORT_C);
        reach_long  = (cnt >= LONG_C);
        unique case (pol)
            POL_SHORT:  allow = present && reach_short;
            POL_LONG:   allow = present && reach_long;
            POL_LOCKED: allow = present && reach_short && aligned;
            POL_BYPASS: allow = present;
            default:    allow = 1'b0;
        endcase
    end

endmodule

// File: rtl/cde_out_gate.sv
module cde_out_gate
    import cde_pkg::*;
#(
    parameter int unsigned SHORT_WAIT = 1024,
    parameter int unsigned LONG_WAIT  = 2048
) (
    input  logic       clk,
    input  logic       pd_n,
    input  logic       clk_ok,
    input  logic       align_ok,
    input  logic       pol_we,
    input  logic [1:0] pol_wdata,
    output logic       lanes_en
);

    localparam int unsigned CW = $clog2(LONG_WAIT + 1);

    gate_state_t   st_d, st_q;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;
    logic          allow;
    logic [1:0]    pol_q;

    cde_cycle_counter #(
        .LIMIT (LONG_WAIT)
    ) u_cnt (
        .clk     (clk),
        .pd_n    (pd_n),
        .run     (clk_ok),
        .cnt_d_o (cnt_d),
        .cnt_q_o (cnt_q)
    );

    cde_policy_decide #(
        .SHORT_WAIT (SHORT_WAIT),
        .LONG_WAIT  (LONG_WAIT)
    ) u_dec (
        .pol     (st_q.pol),
        .cnt     (cnt_d),
        .present (clk_ok),
        .aligned (align_ok),
        .allow   (allow)
    );

    always_comb begin
        st_d    = st_q;
        st_d.en = allow;
        if (pol_we) begin
            st_d.pol = pol_e'(pol_wdata);
        end
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            st_q <= '{pol: POL_SHORT, en: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pol_q    = st_q.pol;
    assign lanes_en = st_q.en;

endmodule

// File: rtl/cde_out_gate_chk.sv
module cde_out_gate_chk #(
    parameter  int unsigned SHORT_WAIT = 1024,
    parameter  int unsigned LONG_WAIT  = 2048,
    localparam int unsigned CW         = $clog2(LONG_WAIT + 1)
) (
    input logic          clk,
    input logic          pd_n,
    input logic          clk_ok,
    input logic          align_ok,
    input logic          pol_we,
    input logic          lanes_en,
    input logic [1:0]    pol_q,
    input logic [CW-1:0] cnt_q
);

    localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_WAIT - 1);
    localparam logic [CW-1:0] LONG_M1  = CW'(LONG_WAIT - 1);
    localparam logic [CW-1:0] LONG_C   = CW'(LONG_WAIT);

    AST_PD_FORCES_OFF: assert property (@(posedge clk)
        !pd_n |-> (!lanes_en && cnt_q == '0 && pol_q == 2'b00)); // R5

    AST_CLK_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!pd_n)
        !clk_ok |=> (!lanes_en && cnt_q == '0)); // R6

    AST_SHORT_HOLDS_OFF: assert property (@(posedge clk) disable iff (!pd_n)
        (pol_q == 2'b00 && cnt_q < SHORT_M1) |=> !lanes_en); // R1

    AST_LONG_HOLDS_OFF: assert property (@(posedge clk) disable iff (!pd_n)
        (pol_q == 2'b01 && cnt_q < LONG_M1) |=> !lanes_en); // R2

    AST_ALIGN_GATES: assert property (@(posedge clk) disable iff (!pd_n)
        (pol_q == 2'b10 && !align_ok) |=> !lanes_en); // R3

    AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!pd_n)
        (pol_q == 2'b11 && clk_ok) |=> lanes_en); // R4

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!pd_n)
        (clk_ok && cnt_q != '0) |=> (cnt_q != '0 && cnt_q <= LONG_C)); // R7

    AST_POLICY_HOLDS: assert property (@(posedge clk) disable iff (!pd_n)
        !pol_we |=> $stable(pol_q)); // R8

endmodule

bind cde_out_gate cde_out_gate_chk #(
    .SHORT_WAIT (SHORT_WAIT),
    .LONG_WAIT  (LONG_WAIT)
) u_chk (
    .clk      (clk),
    .pd_n     (pd_n),
    .clk_ok   (clk_ok),
    .align_ok (align_ok),
    .pol_we   (pol_we),
    .lanes_en (lanes_en),
    .pol_q    (pol_q),
    .cnt_q    (cnt_q)
);

// File: tb/tb_cde_out_gate.sv
module tb_cde_out_gate;

    localparam int CLK_PERIOD = 10;
    localparam int SHORT_W    = 1024;
    localparam int LONG_W     = 2048;

    logic       clk = 1'b0;
    logic       pd_n;
    logic       clk_ok;
    logic       align_ok;
    logic       pol_we;
    logic [1:0] pol_wdata;
    logic       lanes_en;

    int total = 0;
    int bad   = 0;

    int m_n   = 0;
    int m_pol = 0;
    bit m_en  = 1'b0;

    cde_out_gate #(
        .SHORT_WAIT (SHORT_W),
        .LONG_WAIT  (LONG_W)
    ) dut (
        .clk       (clk),
        .pd_n      (pd_n),
        .clk_ok    (clk_ok),
        .align_ok  (align_ok),
        .pol_we    (pol_we),
        .pol_wdata (pol_wdata),
        .lanes_en  (lanes_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic bit exp_allow(int pol, int n, bit ok, bit al);
        if (!ok) return 1'b0;
        case (pol)
            0:       return n >= SHORT_W;
            1:       return n >= LONG_W;
            2:       return (n >= SHORT_W) && al;
            default: return 1'b1;
        endcase
    endfunction

    // reference model, built from the requirements
    always @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            m_n   = 0;
            m_pol = 0;
            m_en  = 1'b0;
        end else begin
            int nn;
            nn   = clk_ok ? ((m_n < LONG_W) ? m_n + 1 : m_n) : 0;
            m_en = exp_allow(m_pol, nn, clk_ok, align_ok);
            m_n  = nn;
            if (pol_we) m_pol = int'(pol_wdata);
        end
    end

    task automatic check(string tag, bit exp);
        total++;
        if (lanes_en !== exp) begin
            bad++;
            $display("FAIL %s: lanes_en actual=%b expected=%b at %0t", tag, lanes_en, exp, $time);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag, m_en);
        pol_we = 1'b0;
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic write_pol(logic [1:0] v, string tag);
        pol_we    = 1'b1;
        pol_wdata = v;
        step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        pd_n      = 1'b0;
        clk_ok    = 1'b0;
        align_ok  = 1'b0;
        pol_we    = 1'b0;
        pol_wdata = 2'b00;
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        check("R5 reset", 1'b0);
        pd_n   = 1'b1;
        clk_ok = 1'b1;

        // R1: default short wait
        run(SHORT_W - 1, "R1");
        check("R1 before threshold", 1'b0);
        step("R1");
        check("R1 at threshold", 1'b1);

        // R7: long presence, no wrap
        run(5000, "R7");
        check("R7 saturated", 1'b1);

        // R6: clock loss clears
        clk_ok = 1'b0;
        step("R6");
        check("R6 drop", 1'b0);
        clk_ok = 1'b1;
        run(SHORT_W - 1, "R6");
        check("R6 restart before", 1'b0);
        step("R6");
        check("R6 restart at threshold", 1'b1);

        // R6: drop on the edge that would have been the threshold
        clk_ok = 1'b0;
        step("R6");
        clk_ok = 1'b1;
        run(SHORT_W - 1, "R6");
        clk_ok = 1'b0;
        step("R6 same-edge drop");
        check("R6 same-edge drop", 1'b0);
        clk_ok = 1'b1;
        step("R6");
        check("R6 counted from zero", 1'b0);

        // R2: long wait
        write_pol(2'b01, "R8");
        clk_ok = 1'b0;
        step("R2");
        clk_ok = 1'b1;
        run(SHORT_W, "R2");
        check("R2 not yet at short count", 1'b0);
        run(LONG_W - SHORT_W - 1, "R2");
        check("R2 before threshold", 1'b0);
        step("R2");
        check("R2 at threshold", 1'b1);

        // R8: policy change keeps the count; old rule decides the write edge
        clk_ok = 1'b0;
        step("R8");
        clk_ok = 1'b1;
        run(1500, "R8");
        check("R8 under long policy", 1'b0);
        write_pol(2'b00, "R8");
        check("R8 write edge uses old policy", 1'b0);
        step("R8");
        check("R8 new policy next edge", 1'b1);

        // R3: alignment gated
        write_pol(2'b10, "R8");
        align_ok = 1'b0;
        clk_ok   = 1'b0;
        step("R3");
        clk_ok = 1'b1;
        run(1100, "R3");
        check("R3 no alignment", 1'b0);
        align_ok = 1'b1;
        step("R3");
        check("R3 aligned", 1'b1);
        align_ok = 1'b0;
        step("R3");
        check("R3 alignment lost", 1'b0);
        align_ok = 1'b1;
        step("R3");
        check("R3 count kept", 1'b1);

        // R4: bypass
        write_pol(2'b11, "R8");
        clk_ok = 1'b0;
        step("R4");
        check("R4 no clock", 1'b0);
        clk_ok   = 1'b1;
        align_ok = 1'b0;
        step("R4");
        check("R4 clock present", 1'b1);

        // R5: power-down mid cycle
        #1;
        pd_n = 1'b0;
        #1;
        check("R5 immediate off", 1'b0);
        @(negedge clk);
        pd_n = 1'b1;
        step("R5");
        check("R5 policy back to short", 1'b0);
        run(SHORT_W - 2, "R5");
        check("R5 before threshold", 1'b0);
        step("R5");
        check("R5 short wait after power-down", 1'b1);

        // random mix
        for (int i = 0; i < 40000; i++) begin
            string tag;
            pd_n   = ($urandom_range(0, 7999) != 0);
            clk_ok = ($urandom_range(0, 2999) != 0);
            if ($urandom_range(0, 49) == 0) align_ok = ~align_ok;
            if ($urandom_range(0, 699) == 0) begin
                pol_we    = 1'b1;
                pol_wdata = 2'($urandom_range(0, 3));
            end
            if (!pd_n)        tag = "R5 random";
            else if (!clk_ok) tag = "R6 random";
            else if (pol_we)  tag = "R8 random";
            else case (m_pol)
                0:       tag = "R1 random";
                1:       tag = "R2 random";
                2:       tag = "R3 random";
                default: tag = "R4 random";
            endcase
            step(tag);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule